// File: doc/BRIEF.md
# Interrupt Presentation Unit

This unit sits between an interrupt source controller and one processor. It keeps at most one candidate interrupt for that processor, given by a 24-bit source number and an 8-bit pending priority, and drives the processor's interrupt line while a candidate is held. Priorities are ordered so that a smaller value is more favoured. The value 0xFF is the least favoured, and when it is the pending priority it means nothing is pending. Each offer from the source controller is either taken or refused. When a taken offer pushes out a candidate that was already held, that older source is handed back to the source side so it can be offered again later.

Software controls the unit through four single-cycle strobes: a write of the processor's current priority, a write of the inter-processor interrupt (IPI) priority, an accept that reads back and acknowledges the held interrupt, and an end-of-interrupt (EOI). These strobes can drop the held candidate, restore the processor priority, forward an EOI to the source side, or ask the source side to resend everything it had to take back. The IPI is presented with the fixed source number 2.

The presentation word has the processor priority in bits 31:24 and the held source number in bits 23:0. A source number of 0 means nothing is held. Every event output is a one-cycle pulse that is registered, so it appears in the cycle after the strobe that causes it.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the interrupt line is low, all pulse outputs are low, and an accept returns the word 0x00000000.
- R2: An accept pulses `ack_valid` in the next cycle with `ack_word` = {processor priority, held source}. It lowers the interrupt line. The processor priority becomes the old pending priority, the held source is cleared, and the pending priority becomes 0xFF.
- R3: An offer whose priority is below the processor priority, when nothing is held or the held pending priority is numerically greater, is taken and raises the line. If a source was held, that source is reported on `displace_src` with a `displace_valid` pulse.
- R4: An offer is refused with an `offer_nack` pulse when its priority is greater than or equal to the processor priority, or when a held interrupt's pending priority is less than or equal to the offered priority. A refused offer leaves the held interrupt unchanged.
- R5: A processor priority write with a smaller value than the current one drops the held source when the new value is less than or equal to the pending priority. The drop reports the source on the displace port and lowers the line. Otherwise the held source is kept.
- R6: A processor priority write that is greater than or equal to the current value, with nothing held, pulses `resend_req`. A smaller value never pulses it.
- R7: An IPI priority write takes effect only if the new value is below the processor priority and no held interrupt has a pending priority less than or equal to it. It then displaces any held source, holds source 2 at the IPI priority, and raises the line.
- R8: An EOI loads the processor priority from bits 31:24 of the written word and pulses `eoi_valid` with bits 23:0 on `eoi_src`. It pulses `resend_req` only when nothing is held.
- R9: Every resend first re-checks the IPI: if the IPI priority is below the processor priority, the IPI is presented as in R7 in the same cycle as the `resend_req` pulse.
- R10: Only one software strobe acts per cycle, chosen in the order accept, EOI, processor priority, IPI priority. The others are ignored. An offer arriving in the same cycle as any software strobe is refused.
- R11: The interrupt line only rises in the cycle after an offer, IPI write, EOI or processor priority write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Source controller offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_nack | output | 1 | Pulse: offer refused |
| displace_valid | output | 1 | Pulse: a held source is handed back |
| displace_src | output | 24 | Source number handed back |
| cppr_wr | input | 1 | Processor priority write strobe |
| cppr_data | input | 8 | New processor priority |
| ipi_wr | input | 1 | IPI priority write strobe |
| ipi_data | input | 8 | New IPI priority |
| ack_rd | input | 1 | Accept strobe |
| ack_valid | output | 1 | Pulse: `ack_word` carries the accepted word |
| ack_word | output | 32 | Presentation word captured by the accept |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_data | input | 32 | EOI word: priority to restore and source number |
| eoi_valid | output | 1 | Pulse: EOI forwarded to source side |
| eoi_src | output | 24 | Source number of the forwarded EOI |
| resend_req | output | 1 | Pulse: source side should resend |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The hardest case to reach is a resend that also presents the IPI. It needs three things at once: an IPI priority that was left pending, a processor priority lowered so the IPI could not be presented when it was written, and a later strobe that both empties the holder and raises the priority again. The stimulus reaches it in two ways. One path is a more favoured priority write that drops the IPI, then an equal rewrite. The other path is an EOI issued while a source offer collides in the same cycle. A further sequence pairs an accept with an IPI write, then uses a later resend to show whether the IPI value was stored.

// File: rtl/ipp_pkg.sv
package ipp_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam prio_t PRIO_NONE = '1;

    typedef struct packed {
        prio_t cur_prio;
        src_t  held_src;
        prio_t pend_prio;
        prio_t ipi_prio;
    } ipp_state_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ACCEPT,
        OP_EOI,
        OP_CPRIO,
        OP_IPI,
        OP_OFFER
    } ipp_op_e;

    typedef struct packed {
        logic  disp_v;
        src_t  disp_src;
        logic  nack;
        logic  eoi_v;
        src_t  eoi_src;
        logic  resend;
        logic  ack_v;
        word_t ack_word;
    } ipp_evt_t;

    function automatic logic is_held(input ipp_state_t s);
        return s.held_src != '0;
    endfunction

    function automatic logic offer_refused(input ipp_state_t s, input prio_t p);
        return (p >= s.cur_prio) || (is_held(s) && (s.pend_prio <= p));
    endfunction

    // Present the IPI unless a held candidate is at least as favoured.
    function automatic void ipi_present(input ipp_state_t s, input src_t ipi_src,
                                        output ipp_state_t o, output logic dv,
                                        output src_t ds);
        o  = s;
        dv = 1'b0;
        ds = '0;
        if (!(is_held(s) && (s.pend_prio <= s.ipi_prio))) begin
            dv          = is_held(s);
            ds          = is_held(s) ? s.held_src : '0;
            o.held_src  = ipi_src;
            o.pend_prio = s.ipi_prio;
        end
    endfunction

    // Resend: re-check the IPI first, then ask the source side to resend.
    function automatic void resend_eval(input ipp_state_t s, input src_t ipi_src,
                                        output ipp_state_t o, output logic dv,
                                        output src_t ds);
        o  = s;
        dv = 1'b0;
        ds = '0;
        if (s.ipi_prio < s.cur_prio) begin
            ipi_present(s, ipi_src, o, dv, ds);
        end
    endfunction

endpackage

// File: rtl/ipp_op_select.sv
module ipp_op_select
    import ipp_pkg::*;
(
    input  logic    ack_rd,
    input  logic    eoi_wr,
    input  logic    cppr_wr,
    input  logic    ipi_wr,
    input  logic    offer_valid,
    output ipp_op_e op,
    output logic    offer_bumped
);
    logic sw_any;

    always_comb begin
        sw_any = ack_rd | eoi_wr | cppr_wr | ipi_wr;
        if (ack_rd)            op = OP_ACCEPT;
        else if (eoi_wr)       op = OP_EOI;
        else if (cppr_wr)      op = OP_CPRIO;
        else if (ipi_wr)       op = OP_IPI;
        else if (offer_valid)  op = OP_OFFER;
        else                   op = OP_IDLE;
        offer_bumped = offer_valid & sw_any;
    end
endmodule

// File: rtl/ipp_next_state.sv
module ipp_next_state
    import ipp_pkg::*;
#(
    parameter int unsigned IPI_SRC = 2
) (
    input  ipp_op_e    op,
    input  logic       offer_bumped,
    input  ipp_state_t st,
    input  src_t       offer_src,
    input  prio_t      offer_prio,
    input  prio_t      cppr_data,
    input  prio_t      ipi_data,
    input  word_t      eoi_data,
    output ipp_state_t ns,
    output ipp_evt_t   ev
);
    localparam src_t IPI_NUM = src_t'(IPI_SRC);

    always_comb begin
        ipp_state_t t;
        logic       dv;
        src_t       ds;
        t  = st;
        dv = 1'b0;
        ds = '0;
        ns = st;
        ev = '0;
        unique case (op)
            OP_ACCEPT: begin
                ev.ack_v     = 1'b1;
                ev.ack_word  = {st.cur_prio, st.held_src};
                ns.cur_prio  = st.pend_prio;
                ns.held_src  = '0;
                ns.pend_prio = PRIO_NONE;
            end
            OP_EOI: begin
                t          = st;
                t.cur_prio = eoi_data[WORD_W-1:SRC_W];
                ev.eoi_v   = 1'b1;
                ev.eoi_src = eoi_data[SRC_W-1:0];
                ns         = t;
                if (!is_held(st)) begin
                    resend_eval(t, IPI_NUM, ns, dv, ds);
                    ev.resend = 1'b1;
                end
            end
            OP_CPRIO: begin
                t          = st;
                t.cur_prio = cppr_data;
                ns         = t;
                if (cppr_data < st.cur_prio) begin
                    if (is_held(st) && (cppr_data <= st.pend_prio)) begin
                        dv           = 1'b1;
                        ds           = st.held_src;
                        ns.held_src  = '0;
                        ns.pend_prio = PRIO_NONE;
                    end
                end else if (!is_held(st)) begin
                    resend_eval(t, IPI_NUM, ns, dv, ds);
                    ev.resend = 1'b1;
                end
            end
            OP_IPI: begin
                t          = st;
                t.ipi_prio = ipi_data;
                ns         = t;
                if (ipi_data < st.cur_prio) begin
                    ipi_present(t, IPI_NUM, ns, dv, ds);
                end
            end
            OP_OFFER: begin
                if (offer_refused(st, offer_prio)) begin
                    ev.nack = 1'b1;
                end else begin
                    dv           = is_held(st);
                    ds           = is_held(st) ? st.held_src : '0;
                    ns.held_src  = offer_src;
                    ns.pend_prio = offer_prio;
                end
            end
            default: ns = st;
        endcase
        ev.disp_v   = dv;
        ev.disp_src = ds;
        ev.nack     = ev.nack | offer_bumped;
    end
endmodule

// File: rtl/ipp_event_reg.sv
module ipp_event_reg
    import ipp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ipp_evt_t ev_d,
    input  logic     irq_d,
    output ipp_evt_t ev_q,
    output logic     irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            ev_q  <= ev_d;
            irq_q <= irq_d;
        end
    end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
    import ipp_pkg::*;
#(
    parameter int unsigned IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              offer_nack,
    output logic              displace_valid,
    output logic [SRC_W-1:0]  displace_src,
    input  logic              cppr_wr,
    input  logic [PRIO_W-1:0] cppr_data,
    input  logic              ipi_wr,
    input  logic [PRIO_W-1:0] ipi_data,
    input  logic              ack_rd,
    output logic              ack_valid,
    output logic [WORD_W-1:0] ack_word,
    input  logic              eoi_wr,
    input  logic [WORD_W-1:0] eoi_data,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req,
    output logic              irq_out
);
    localparam ipp_state_t RESET_STATE = '{
        cur_prio:  '0,
        held_src:  '0,
        pend_prio: PRIO_NONE,
        ipi_prio:  PRIO_NONE
    };

    ipp_op_e    op;
    logic       offer_bumped;
    ipp_state_t st_q, st_d;
    ipp_evt_t   ev_d, ev_q;

    ipp_op_select u_sel (
        .ack_rd       (ack_rd),
        .eoi_wr       (eoi_wr),
        .cppr_wr      (cppr_wr),
        .ipi_wr       (ipi_wr),
        .offer_valid  (offer_valid),
        .op           (op),
        .offer_bumped (offer_bumped)
    );

    ipp_next_state #(.IPI_SRC(IPI_SRC)) u_ns (
        .op           (op),
        .offer_bumped (offer_bumped),
        .st           (st_q),
        .offer_src    (offer_src),
        .offer_prio   (offer_prio),
        .cppr_data    (cppr_data),
        .ipi_data     (ipi_data),
        .eoi_data     (eoi_data),
        .ns           (st_d),
        .ev           (ev_d)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= RESET_STATE;
        else     st_q <= st_d;
    end

    ipp_event_reg u_evr (
        .clk   (clk),
        .rst   (rst),
        .ev_d  (ev_d),
        .irq_d (is_held(st_d)),
        .ev_q  (ev_q),
        .irq_q (irq_out)
    );

    assign offer_nack     = ev_q.nack;
    assign displace_valid = ev_q.disp_v;
    assign displace_src   = ev_q.disp_src;
    assign ack_valid      = ev_q.ack_v;
    assign ack_word       = ev_q.ack_word;
    assign eoi_valid      = ev_q.eoi_v;
    assign eoi_src        = ev_q.eoi_src;
    assign resend_req     = ev_q.resend;
endmodule

// File: rtl/ipp_checker.sv
module ipp_checker
    import ipp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        offer_valid,
    input logic        offer_nack,
    input logic        cppr_wr,
    input logic        ipi_wr,
    input logic        ack_rd,
    input logic        ack_valid,
    input logic        eoi_wr,
    input word_t       eoi_data,
    input logic        eoi_valid,
    input src_t        eoi_src,
    input logic        irq_out
);
    logic sw_any;
    assign sw_any = ack_rd | eoi_wr | cppr_wr | ipi_wr;

    // R2
    accept_lowers_line_chk: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> (ack_valid && !irq_out));

    // R10
    offer_collision_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && sw_any) |=> offer_nack);

    // R8
    eoi_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack_rd) |=> (eoi_valid && (eoi_src == $past(eoi_data[SRC_W-1:0]))));

    // R3
    offer_answered_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !sw_any) |=> (offer_nack || irq_out));

    // R11
    line_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(offer_valid || ipi_wr || eoi_wr || cppr_wr));
endmodule

bind intr_present_unit ipp_checker u_ipp_chk (
    .clk         (clk),
    .rst         (rst),
    .offer_valid (offer_valid),
    .offer_nack  (offer_nack),
    .cppr_wr     (cppr_wr),
    .ipi_wr      (ipi_wr),
    .ack_rd      (ack_rd),
    .ack_valid   (ack_valid),
    .eoi_wr      (eoi_wr),
    .eoi_data    (eoi_data),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src),
    .irq_out     (irq_out)
);

// File: tb/intr_present_unit_test.sv
`timescale 1ns/100ps
module intr_present_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        offer_valid = 0, cppr_wr = 0, ipi_wr = 0, ack_rd = 0, eoi_wr = 0;
    logic [23:0] offer_src = 0;
    logic [7:0]  offer_prio = 0, cppr_data = 0, ipi_data = 0;
    logic [31:0] eoi_data = 0;
    logic        offer_nack, displace_valid, ack_valid, eoi_valid, resend_req, irq_out;
    logic [23:0] displace_src, eoi_src;
    logic [31:0] ack_word;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intr_present_unit uut (
        .clk(clk), .rst(rst),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_nack(offer_nack), .displace_valid(displace_valid), .displace_src(displace_src),
        .cppr_wr(cppr_wr), .cppr_data(cppr_data), .ipi_wr(ipi_wr), .ipi_data(ipi_data),
        .ack_rd(ack_rd), .ack_valid(ack_valid), .ack_word(ack_word),
        .eoi_wr(eoi_wr), .eoi_data(eoi_data), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req), .irq_out(irq_out)
    );

    typedef struct {
        logic        irq;
        logic        ack_v;
        logic [31:0] ack_w;
        logic        disp_v;
        logic [23:0] disp_s;
        logic        nack;
        logic        eoi_v;
        logic [23:0] eoi_s;
        logic        resend;
        string       tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t mk(logic irq, logic ack_v, logic [31:0] ack_w,
                                logic disp_v, logic [23:0] disp_s, logic nack,
                                logic eoi_v, logic [23:0] eoi_s, logic resend, string tag);
        exp_t x;
        x.irq = irq; x.ack_v = ack_v; x.ack_w = ack_w; x.disp_v = disp_v;
        x.disp_s = disp_s; x.nack = nack; x.eoi_v = eoi_v; x.eoi_s = eoi_s;
        x.resend = resend; x.tag = tag;
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input string field,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
        end
    endtask

    // Monitor: compares each registered result one step after its stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                chk(irq_out === x.irq, x.tag, "irq_out", 32'(irq_out), 32'(x.irq));
                chk(ack_valid === x.ack_v, x.tag, "ack_valid", 32'(ack_valid), 32'(x.ack_v));
                chk(ack_word === x.ack_w, x.tag, "ack_word", ack_word, x.ack_w);
                chk(displace_valid === x.disp_v, x.tag, "displace_valid",
                    32'(displace_valid), 32'(x.disp_v));
                chk(displace_src === x.disp_s, x.tag, "displace_src",
                    32'(displace_src), 32'(x.disp_s));
                chk(offer_nack === x.nack, x.tag, "offer_nack", 32'(offer_nack), 32'(x.nack));
                chk(eoi_valid === x.eoi_v, x.tag, "eoi_valid", 32'(eoi_valid), 32'(x.eoi_v));
                chk(eoi_src === x.eoi_s, x.tag, "eoi_src", 32'(eoi_src), 32'(x.eoi_s));
                chk(resend_req === x.resend, x.tag, "resend_req",
                    32'(resend_req), 32'(x.resend));
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic drv(input logic a, input logic e, input logic c, input logic i,
                       input logic o, input logic [31:0] ed, input logic [7:0] cd,
                       input logic [7:0] id, input logic [23:0] os, input logic [7:0] op,
                       input exp_t x);
        @(negedge clk);
        ack_rd = a; eoi_wr = e; cppr_wr = c; ipi_wr = i; offer_valid = o;
        eoi_data = ed; cppr_data = cd; ipi_data = id; offer_src = os; offer_prio = op;
        q.push_back(x);
    endtask

    task automatic idle(input exp_t x);
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, x);
    endtask
    task automatic offer(input logic [23:0] s, input logic [7:0] p, input exp_t x);
        drv(0, 0, 0, 0, 1, 0, 0, 0, s, p, x);
    endtask
    task automatic accept(input exp_t x);
        drv(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, x);
    endtask
    task automatic wr_cprio(input logic [7:0] v, input exp_t x);
        drv(0, 0, 1, 0, 0, 0, v, 0, 0, 0, x);
    endtask
    task automatic wr_ipi(input logic [7:0] v, input exp_t x);
        drv(0, 0, 0, 1, 0, 0, 0, v, 0, 0, x);
    endtask
    task automatic eoi(input logic [31:0] w, input exp_t x);
        drv(0, 1, 0, 0, 0, w, 0, 0, 0, 0, x);
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle(mk(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, "R1 reset outputs"));
        accept(mk(0, 1, 32'h00000000, 0, 0, 0, 0, 0, 0, "R1 accept after reset"));
        // R6 equal priority write with nothing held requests resend
        wr_cprio(8'hFF, mk(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 equal write resend"));
        // R3 take offers, R4 refuse
        offer(24'h100, 8'h05, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 first offer taken"));
        offer(24'h200, 8'h05, mk(1, 0, 0, 0, 0, 1, 0, 0, 0, "R4 equal pending refused"));
        offer(24'h300, 8'h03, mk(1, 0, 0, 1, 24'h100, 0, 0, 0, 0, "R3 better offer displaces"));
        offer(24'h400, 8'hFF, mk(1, 0, 0, 0, 0, 1, 0, 0, 0, "R4 offer at cpu priority"));
        // R2 accept
        accept(mk(0, 1, 32'hFF000300, 0, 0, 0, 0, 0, 0, "R2 accept word"));
        offer(24'h500, 8'h03, mk(0, 0, 0, 0, 0, 1, 0, 0, 0, "R4 boundary equal cpu prio"));
        // R8 EOI with nothing held
        eoi(32'hFF000300, mk(0, 0, 0, 0, 0, 0, 1, 24'h300, 1, "R8 eoi resend"));
        // R7 IPI
        wr_ipi(8'h10, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 ipi presented"));
        offer(24'h600, 8'h10, mk(1, 0, 0, 0, 0, 1, 0, 0, 0, "R4 tie with ipi"));
        wr_ipi(8'h08, mk(1, 0, 0, 1, 24'h2, 0, 0, 0, 0, "R7 better ipi displaces"));
        wr_ipi(8'h20, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 worse ipi no effect"));
        // R5 more favoured cpu priority drops held
        wr_cprio(8'h05, mk(0, 0, 0, 1, 24'h2, 0, 0, 0, 0, "R5 drop held"));
        accept(mk(0, 1, 32'h05000000, 0, 0, 0, 0, 0, 0, "R2 accept empty"));
        wr_cprio(8'h40, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 lower write no resend"));
        // R9 resend re-evaluates IPI
        wr_cprio(8'h40, mk(1, 0, 0, 0, 0, 0, 0, 0, 1, "R9 resend presents ipi"));
        wr_cprio(8'h30, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5 held kept"));
        accept(mk(0, 1, 32'h30000002, 0, 0, 0, 0, 0, 0, "R2 accept ipi"));
        // R10 EOI and offer collide
        drv(0, 1, 0, 0, 1, 32'h30000002, 0, 0, 24'h700, 8'h01,
            mk(1, 0, 0, 0, 0, 1, 1, 24'h2, 1, "R10 eoi beats offer R9"));
        offer(24'h800, 8'h10, mk(1, 0, 0, 1, 24'h2, 0, 0, 0, 0, "R3 offer displaces ipi"));
        accept(mk(0, 1, 32'h30000800, 0, 0, 0, 0, 0, 0, "R2 accept source"));
        // R10 accept beats IPI write; IPI value must stay 0x20
        drv(1, 0, 0, 1, 0, 0, 0, 8'hFF, 0, 0,
            mk(0, 1, 32'h10000000, 0, 0, 0, 0, 0, 0, "R10 accept beats ipi write"));
        wr_cprio(8'hFF, mk(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10 ipi write was ignored"));
        // R8 EOI while held: no resend
        eoi(32'h00000800, mk(1, 0, 0, 0, 0, 0, 1, 24'h800, 0, "R8 eoi held no resend"));
        accept(mk(0, 1, 32'h00000002, 0, 0, 0, 0, 0, 0, "R8 eoi restored priority"));
        idle(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle line stays low"));
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule